// File: doc/BRIEF.md
# Packed Register-Write Command Decoder

This block sits between a fetch engine and an internal register bus. The fetch engine reads 32-bit command words from a buffer in memory. The block turns them into single register writes, one per clock at most. Commands come in fixed packets of five words. The first word holds four 8-bit register indices, one per byte. The four words after it are the values to write.

Each index is expanded to a byte address in one of two register windows. Bit 7 of the index picks the window. Some indices in the lower window land on the execute alias of a drawing register. A write there carries a go strobe that tells the drawing engine to start. Writes to the padding register fill unused slots, so they are dropped.

The fetch engine tags the final word of a stream. Once every write of that stream has left the block, the status word reports that the stream has ended. It also reports whether the drawing engine is busy, and an idle flag combines the two. If a stream ends part-way through a packet, a sticky error flag is set.

Top module: `regpack_decoder`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, and `wr_valid_o`, `wr_go_o`, `status_o`, `idle_o` and `stream_err_o` are all 0.
- R2: A packet is one index word followed by four data words. Byte k of the index word (bits 8k+7..8k) belongs to data word k. The writes leave in the order k = 0, 1, 2, 3, in the four clock cycles after the edge that accepts the fourth data word. `cmd_ready_o` is 0 from that edge until the edge that issues the last write.
- R3: An index with bit 7 clear is written to byte address 0x1C00 + index×4.
- R4: An index with bit 7 set is written to byte address 0x2C00 + (index & 0x7F)×4. `wr_go_o` stays 0 for these writes.
- R5: `wr_go_o` is 1 with a write if and only if its index lies in 0x40..0x7F.
- R6: An index that maps to the padding address 0x1C54 (index 0x15) uses its slot cycle, but `wr_valid_o` stays 0 in that cycle.
- R7: `status_o[16]` equals `engine_busy_i` delayed by one clock. `status_o[0]` and every bit other than 16 and 17 read 0.
- R8: `cmd_last_i` on the fourth data word sets `status_o[17]` in the same cycle as that packet's last write. `idle_o` is `status_o[17]` AND NOT `status_o[16]`. Bit 17 clears on the next accepted word.
- R9: `cmd_last_i` on any other word of a packet sets `stream_err_o` (sticky until reset) and `status_o[17]`, and the partial packet is dropped without writes. The next word accepted is taken as an index word.
- R10: `xfer_mode_i` selects the transfer mode: 0 is general, 1 to 3 are other modes. When it is not 0, packets are consumed with normal timing but no write is issued.
- R11: Reset clears the word counter, the stored indices, the stream-end flag and the error flag. A packet begun before reset is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_mode_i | input | 2 | Transfer mode, 0 = general |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Block can accept a command word |
| cmd_data_i | input | 32 | Command word |
| cmd_last_i | input | 1 | Word is the last of the stream |
| wr_valid_o | output | 1 | Register write strobe |
| wr_addr_o | output | 16 | Register byte address |
| wr_data_o | output | 32 | Register write value |
| wr_go_o | output | 1 | Write also starts the drawing engine |
| engine_busy_i | input | 1 | Drawing engine busy |
| status_o | output | 32 | Bit 16 engine busy, bit 17 stream ended |
| idle_o | output | 1 | Stream ended and engine not busy |
| stream_err_o | output | 1 | Stream ended inside a packet |

## Verification
The hardest case to reach from the ports is a stream that ends in the middle of a packet. After it, the word counter must be back at the index position, or every later packet would be decoded with the wrong alignment. The bench reaches it by tagging the second data word as last. It then confirms that no write comes out and sends a full packet whose addresses are checked, which shows the realignment. A sweep of all 256 index values, four per packet, covers both windows, the execute aliases and the padding slot. The same kind of check, a partial packet followed by a full one, is repeated across a reset.

// File: rtl/regpack_pkg.sv
package regpack_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_ISSUE   = 1'b1
  } seq_state_e;

  localparam logic [1:0] MODE_GENERAL = 2'd0;

  localparam int STAT_TRAP_BIT = 0;
  localparam int STAT_BUSY_BIT = 16;
  localparam int STAT_END_BIT  = 17;

endpackage

// File: rtl/regpack_index_decode.sv
module regpack_index_decode #(
  parameter int                IDX_W     = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00,
  parameter logic [ADDR_W-1:0] PAD_ADDR  = 16'h1C54
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              go_o,
  output logic              pad_o
);

  localparam int WIN_SEL_BIT = IDX_W - 1;
  localparam int EXEC_BIT    = IDX_W - 2;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;

  always_comb begin
    offset = ADDR_W'({idx_i[EXEC_BIT:0], 2'b00});
    base   = idx_i[WIN_SEL_BIT] ? WIN1_BASE : WIN0_BASE;
    addr_o = base + offset;
    go_o   = !idx_i[WIN_SEL_BIT] && idx_i[EXEC_BIT];
    pad_o  = (addr_o == PAD_ADDR);
  end

endmodule

// File: rtl/regpack_sequencer.sv
module regpack_sequencer
  import regpack_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                IDX_W     = 8,
  parameter int                SLOTS     = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00,
  parameter logic [ADDR_W-1:0] PAD_ADDR  = 16'h1C54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        xfer_mode_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_last_i,
  output logic [IDX_W-1:0]  cur_idx_o,
  input  logic [ADDR_W-1:0] dec_addr_i,
  input  logic              dec_go_i,
  input  logic              dec_pad_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_go_o,
  output logic              stream_done_o,
  output logic              stream_err_o
);

  localparam int                CNT_W    = $clog2(SLOTS + 1);
  localparam int                SLOT_W   = $clog2(SLOTS);
  localparam int                HDR_W    = SLOTS * IDX_W;
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(4 << (IDX_W - 1));
  localparam logic [ADDR_W-1:0] GO_LO    = WIN0_BASE + (WIN_SPAN >> 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] slot_mem [SLOTS];
  logic              pend_last_q;
  logic              done_q;
  logic              err_q;
  logic              wr_valid_q;
  logic              wr_go_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  logic [IDX_W-1:0]  slot_idx [SLOTS];
  logic              accept;
  logic              is_hdr;
  logic              pkt_full;
  logic              last_slot;
  logic              mode_ok;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot_idx
    assign slot_idx[g] = hdr_q[g*IDX_W +: IDX_W];
  end

  assign cmd_ready_o = (state_q == ST_COLLECT);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign is_hdr      = (cnt_q == '0);
  assign pkt_full    = (cnt_q == CNT_W'(SLOTS));
  assign last_slot   = (slot_q == SLOT_W'(SLOTS - 1));
  assign mode_ok     = (xfer_mode_i == MODE_GENERAL);
  assign cur_idx_o   = slot_idx[slot_q];

  // data slot storage, no reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (accept && !is_hdr) begin
      slot_mem[SLOT_W'(cnt_q - CNT_W'(1))] <= cmd_data_i;
    end
  end

  always_ff @(posedge clk) begin
    wr_data_q <= slot_mem[slot_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_COLLECT;
      cnt_q       <= '0;
      slot_q      <= '0;
      hdr_q       <= '0;
      pend_last_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (accept) begin
            done_q <= 1'b0;
            if (is_hdr) begin
              hdr_q <= cmd_data_i[HDR_W-1:0];
            end
            if (pkt_full) begin
              cnt_q       <= '0;
              slot_q      <= '0;
              pend_last_q <= cmd_last_i;
              state_q     <= ST_ISSUE;
            end else if (cmd_last_i) begin
              cnt_q  <= '0;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_ISSUE: begin
          slot_q <= slot_q + SLOT_W'(1);
          if (last_slot) begin
            state_q     <= ST_COLLECT;
            pend_last_q <= 1'b0;
            if (pend_last_q) begin
              done_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid_q <= 1'b0;
      wr_go_q    <= 1'b0;
      wr_addr_q  <= '0;
    end else begin
      wr_valid_q <= (state_q == ST_ISSUE) && mode_ok && !dec_pad_i;
      wr_go_q    <= (state_q == ST_ISSUE) && mode_ok && !dec_pad_i && dec_go_i;
      wr_addr_q  <= dec_addr_i;
    end
  end

  assign wr_valid_o    = wr_valid_q;
  assign wr_go_o       = wr_go_q;
  assign wr_addr_o     = wr_addr_q;
  assign wr_data_o     = wr_data_q;
  assign stream_done_o = done_q;
  assign stream_err_o  = err_q;

  AST_WRITE_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> $past(!cmd_ready_o)); // R2

  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> ((wr_addr_o >= WIN0_BASE && wr_addr_o < WIN0_BASE + WIN_SPAN) ||
                    (wr_addr_o >= WIN1_BASE && wr_addr_o < WIN1_BASE + WIN_SPAN))); // R3

  AST_GO_IN_EXEC_ALIAS: assert property (@(posedge clk) disable iff (rst)
    wr_go_o |-> (wr_valid_o && wr_addr_o >= GO_LO && wr_addr_o < WIN0_BASE + WIN_SPAN)); // R5

  AST_NO_PAD_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> (wr_addr_o != PAD_ADDR)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    stream_err_o |=> stream_err_o); // R9

  AST_MODE_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> $past(xfer_mode_i == MODE_GENERAL)); // R10

endmodule

// File: rtl/regpack_status.sv
module regpack_status
  import regpack_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              engine_busy_i,
  input  logic              stream_done_i,
  output logic [STAT_W-1:0] status_o,
  output logic              idle_o
);

  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= engine_busy_i;
    end
  end

  always_comb begin
    status_o                = '0;
    status_o[STAT_BUSY_BIT] = busy_q;
    status_o[STAT_END_BIT]  = stream_done_i;
    idle_o = (status_o[STAT_END_BIT] && !status_o[STAT_BUSY_BIT] && !status_o[STAT_TRAP_BIT]);
  end

  AST_BUSY_TRACKS_HIGH: assert property (@(posedge clk) disable iff (rst)
    engine_busy_i |=> status_o[STAT_BUSY_BIT]); // R7

  AST_BUSY_TRACKS_LOW: assert property (@(posedge clk) disable iff (rst)
    !engine_busy_i |=> !status_o[STAT_BUSY_BIT]); // R7

endmodule

// File: rtl/regpack_decoder.sv
module regpack_decoder
  import regpack_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                IDX_W     = 8,
  parameter int                SLOTS     = 4,
  parameter int                ADDR_W    = 16,
  parameter int                STAT_W    = 32,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00,
  parameter logic [ADDR_W-1:0] PAD_ADDR  = 16'h1C54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        xfer_mode_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_last_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_go_o,
  input  logic              engine_busy_i,
  output logic [STAT_W-1:0] status_o,
  output logic              idle_o,
  output logic              stream_err_o
);

  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_go;
  logic              dec_pad;
  logic              stream_done;

  regpack_index_decode #(
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W),
    .WIN0_BASE(WIN0_BASE),
    .WIN1_BASE(WIN1_BASE),
    .PAD_ADDR (PAD_ADDR)
  ) u_decode (
    .idx_i (cur_idx),
    .addr_o(dec_addr),
    .go_o  (dec_go),
    .pad_o (dec_pad)
  );

  regpack_sequencer #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .SLOTS    (SLOTS),
    .ADDR_W   (ADDR_W),
    .WIN0_BASE(WIN0_BASE),
    .WIN1_BASE(WIN1_BASE),
    .PAD_ADDR (PAD_ADDR)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .xfer_mode_i  (xfer_mode_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_data_i   (cmd_data_i),
    .cmd_last_i   (cmd_last_i),
    .cur_idx_o    (cur_idx),
    .dec_addr_i   (dec_addr),
    .dec_go_i     (dec_go),
    .dec_pad_i    (dec_pad),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .wr_go_o      (wr_go_o),
    .stream_done_o(stream_done),
    .stream_err_o (stream_err_o)
  );

  regpack_status #(
    .STAT_W(STAT_W)
  ) u_status (
    .clk          (clk),
    .rst          (rst),
    .engine_busy_i(engine_busy_i),
    .stream_done_i(stream_done),
    .status_o     (status_o),
    .idle_o       (idle_o)
  );

endmodule

// File: tb/regpack_decoder_tb.sv
`timescale 1ns/1ps
module regpack_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  xfer_mode = 2'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = '0;
  logic        cmd_last = 1'b0;
  logic        wr_valid;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_go;
  logic        engine_busy = 1'b0;
  logic [31:0] status;
  logic        idle;
  logic        stream_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  regpack_decoder dut_i (
    .clk          (clk),
    .rst          (rst),
    .xfer_mode_i  (xfer_mode),
    .cmd_valid_i  (cmd_valid),
    .cmd_ready_o  (cmd_ready),
    .cmd_data_i   (cmd_data),
    .cmd_last_i   (cmd_last),
    .wr_valid_o   (wr_valid),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .wr_go_o      (wr_go),
    .engine_busy_i(engine_busy),
    .status_o     (status),
    .idle_o       (idle),
    .stream_err_o (stream_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d, input logic last);
    cmd_valid = 1'b1;
    cmd_data  = d;
    cmd_last  = last;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_last  = 1'b0;
  endtask

  // sends one packet and checks the four slot cycles that follow
  task automatic run_packet(input logic [31:0] hdr, input logic [31:0] dbase,
                            input logic last, input logic writes_on);
    send_word(hdr, 1'b0);
    for (int s = 0; s < 4; s++) send_word(dbase + 32'(s), last && (s == 3));
    chk("R2 ready low after packet", {31'd0, cmd_ready}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      logic [7:0]  idx;
      logic [15:0] eaddr;
      logic        ego;
      logic        evalid;
      @(negedge clk);
      idx    = hdr[8*s +: 8];
      eaddr  = idx[7] ? (16'h2C00 + 16'(idx[6:0]) * 16'd4) : (16'h1C00 + 16'(idx) * 16'd4);
      ego    = !idx[7] && idx[6];
      evalid = writes_on && (eaddr != 16'h1C54);
      if (!writes_on) chk("R10 no write in other mode", {31'd0, wr_valid}, 32'd0);
      else if (eaddr == 16'h1C54) chk("R6 padding dropped", {31'd0, wr_valid}, 32'd0);
      else chk("R2 write valid", {31'd0, wr_valid}, 32'd1);
      if (evalid) begin
        if (idx[7]) chk("R4 window 1 address", {16'd0, wr_addr}, {16'd0, eaddr});
        else        chk("R3 window 0 address", {16'd0, wr_addr}, {16'd0, eaddr});
        chk("R5 go strobe", {31'd0, wr_go}, {31'd0, ego});
        chk("R2 data order", wr_data, dbase + 32'(s));
      end
      chk("R2 ready during issue", {31'd0, cmd_ready}, {31'd0, s == 3});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1 wr_valid", {31'd0, wr_valid}, 32'd0);
    chk("R1 wr_go", {31'd0, wr_go}, 32'd0);
    chk("R1 status", status, 32'd0);
    chk("R1 idle", {31'd0, idle}, 32'd0);
    chk("R1 err", {31'd0, stream_err}, 32'd0);

    // sweep every index value, four per packet
    for (int k = 0; k < 64; k++) begin
      logic [7:0] b0;
      b0 = 8'(k * 4);
      run_packet({b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0}, 32'hA000_0000 | 32'(k << 8), 1'b0, 1'b1);
    end
    // reversed and mixed-window ordering
    run_packet({8'h15, 8'h40, 8'hFF, 8'h7F}, 32'hB000_0000, 1'b0, 1'b1);

    // R7 status busy bit and reserved bits
    engine_busy = 1'b1;
    @(negedge clk);
    chk("R7 busy bit set", {31'd0, status[16]}, 32'd1);
    chk("R7 other bits zero", status & ~32'h0003_0000, 32'd0);
    engine_busy = 1'b0;
    @(negedge clk);
    chk("R7 busy bit clear", {31'd0, status[16]}, 32'd0);

    // R8 stream end on a full packet
    run_packet({8'h81, 8'h22, 8'h43, 8'h04}, 32'hC000_0000, 1'b1, 1'b1);
    chk("R8 stream end bit", {31'd0, status[17]}, 32'd1);
    chk("R8 idle when not busy", {31'd0, idle}, 32'd1);
    engine_busy = 1'b1;
    @(negedge clk);
    chk("R8 idle drops when busy", {31'd0, idle}, 32'd0);
    chk("R8 end bit holds", {31'd0, status[17]}, 32'd1);
    engine_busy = 1'b0;
    send_word(32'h0302_0100, 1'b0);
    chk("R8 end bit cleared by new word", {31'd0, status[17]}, 32'd0);
    for (int s = 0; s < 4; s++) send_word(32'hD000_0000 + 32'(s), 1'b0);
    repeat (4) @(negedge clk);

    // R9 end marker inside a packet
    chk("R9 err clear before", {31'd0, stream_err}, 32'd0);
    send_word(32'h4443_4241, 1'b0);
    send_word(32'hE000_0000, 1'b0);
    send_word(32'hE000_0001, 1'b1);
    chk("R9 err set", {31'd0, stream_err}, 32'd1);
    chk("R9 end bit set", {31'd0, status[17]}, 32'd1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R9 partial packet dropped", {31'd0, wr_valid}, 32'd0);
    end
    run_packet({8'h8A, 8'h09, 8'h58, 8'h01}, 32'hF000_0000, 1'b0, 1'b1);
    chk("R9 err sticky", {31'd0, stream_err}, 32'd1);

    // R10 non-general mode consumes packets silently
    xfer_mode = 2'd2;
    run_packet({8'h04, 8'h03, 8'h02, 8'h01}, 32'h1000_0000, 1'b0, 1'b0);
    xfer_mode = 2'd3;
    run_packet({8'h44, 8'h83, 8'h42, 8'h01}, 32'h1100_0000, 1'b0, 1'b0);
    xfer_mode = 2'd0;

    // R11 reset mid-packet
    send_word(32'h0807_0605, 1'b0);
    send_word(32'h2000_0000, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 err cleared", {31'd0, stream_err}, 32'd0);
    chk("R11 status cleared", status, 32'd0);
    chk("R11 ready", {31'd0, cmd_ready}, 32'd1);
    run_packet({8'h90, 8'h50, 8'h10, 8'h11}, 32'h3000_0000, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule